// File: doc/BRIEF.md
# Multi-Mode PWM Timer Counter

This block is a W-bit timer counter (16 bits by default) driven through a small register port. The counter can run up, run down, or sweep up and down in one of three center-aligned variants. It wraps against a reload limit, and that limit can be double-buffered through a shadow copy. A one-shot option halts the counter at its first update event. A single compare channel latches a sticky hit flag, and a free-running divided tick serves downstream filters and dead-band logic.

Software accesses five registers through one address and a write strobe. Reads are combinational on the address. The registers are:

- address 0: control
- address 1: reload
- address 2: compare
- address 3: status
- address 4: count (readable and writable)

The control fields are run (bit 0), one-shot (bit 1), down (bit 2), align mode (bits 4:3), buffered reload (bit 5) and tick divider (bits 7:6). Bits 15:8 of control read as zero.

The block has two outputs besides the read data. `upd_o` is a one-cycle pulse for each update event. `tick_o` is the divided sampling enable.

Top module: `tmr_core`

## Requirements
- R1: After reset, control, count, compare and status read 0 and reload reads 16'hFFFF. Control bits 15:8 always read 0, even after a write of ones.
- R2: `tick_o` pulses once every 1, 2 or 4 clocks for divider codes 00, 01 and 10. Code 11 behaves as code 00. The tick runs whether or not the counter runs.
- R3: With align mode 00, down=0 and run=1, the count steps +1 per clock. From the reload value it goes to 0, and `upd_o` is 1 in the cycle that shows that 0.
- R4: With align mode 00, down=1 and run=1, the count steps -1 per clock. From 0 it goes to the reload value, and `upd_o` is 1 in the cycle that shows it.
- R5: With align mode 01, 10 or 11 and a reload value A≥3, starting from 0, the count goes 0,1,…,A-1,A-2,…,1,0 and repeats. `upd_o` pulses after each turn-around. Control bit 2 reads 1 while descending and 0 while ascending, and writes to it are ignored.
- R6: While running, a count equal to compare sets the status bit 0 flag. In modes 00 and 11 it is set in either direction. In mode 01 it is set only while descending, and in mode 10 only while ascending.
- R7: The status bit 0 flag is sticky. Writing 0 to status bit 0 clears it, and writing 1 leaves it unchanged.
- R8: With buffered reload (bit 5) at 0, a reload write takes effect on the next count step.
- R9: With buffered reload at 1, a reload write goes to a shadow copy, which is what reload reads back. The active limit takes the shadow value only at an update event.
- R10: With one-shot set, the first update event clears the run bit, and the count stays at the value it wrapped to.
- R11: A control write that changes align mode from 00 to any nonzero code is ignored in that field while run is 1. With run at 0 it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address (0 control, 1 reload, 2 compare, 3 status, 4 count) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| upd_o | output | 1 | One-cycle update-event pulse |
| tick_o | output | 1 | Divided sampling-clock enable |

## Verification
A register write lands on the clock edge that ends the strobe cycle. A run bit written there takes effect at once, so the count has advanced k steps when it is read at the falling edge k clocks after the write. The bench therefore counts falling edges from the end of the start write and compares the count, direction bit, status flag and `upd_o` against closed-form positions in the sweep.

A compare hit becomes visible one clock after the matching count is shown. The expected flag therefore includes only positions shown before the sampling point. The tick is counted over 16 consecutive falling edges, so the result does not depend on the divider phase.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer counter: register addresses,
// control-field bit positions and the alignment mode codes.
package tmr_pkg;

    localparam int TMR_W = 16;

    typedef enum logic [2:0] {
        ADR_CTRL   = 3'd0,
        ADR_RELOAD = 3'd1,
        ADR_CMP    = 3'd2,
        ADR_STAT   = 3'd3,
        ADR_COUNT  = 3'd4
    } tmr_addr_e;

    typedef enum logic [1:0] {
        ALN_EDGE = 2'b00,
        ALN_DN   = 2'b01,
        ALN_UP   = 2'b10,
        ALN_BOTH = 2'b11
    } tmr_aln_e;

    localparam int CB_RUN  = 0;
    localparam int CB_OPS  = 1;
    localparam int CB_DIR  = 2;
    localparam int CB_ALN  = 3;
    localparam int CB_PRE  = 5;
    localparam int CB_DIV  = 6;

endpackage

// File: rtl/tmr_tick_gen.sv
// Sampling-tick generator. A free-running phase counter produces a
// one-cycle enable every 1, 2 or 4 clocks, chosen by a 2-bit code.
// Assumes: code 2'b11 is not meant to be used; it maps to divide-by-1.
module tmr_tick_gen #(
    parameter int PW = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div,
    output logic       tick
);
    logic [PW-1:0] phase_q;
    logic [PW-1:0] mask;

    // Phase mask for the selected ratio.
    always_comb begin
        case (div)
            2'b01:   mask = PW'(1);
            2'b10:   mask = PW'(3);
            default: mask = '0;
        endcase
    end

    // Free-running phase counter, independent of the counter enable.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + PW'(1);
    end

    assign tick = ((phase_q & mask) == mask);
endmodule

// File: rtl/tmr_counter.sv
// Count engine. Steps once per clock while run is set. In edge mode it
// uses the supplied direction; in center mode it keeps its own direction,
// which restarts as ascending whenever center mode is off.
// Assumes: center mode needs a limit of at least 3 for a full sweep;
// below 2 it holds at 0 and reports an update each step.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         center,
    input  logic         edge_down,
    input  logic [W-1:0] limit,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         cdir,
    output logic         wrap
);
    logic [W-1:0] cnt_nxt;
    logic         dir_nxt;

    // Next count, next center direction and update detection.
    always_comb begin
        cnt_nxt = cnt;
        dir_nxt = cdir;
        wrap    = 1'b0;
        if (run) begin
            if (!center) begin
                if (!edge_down) begin
                    if (cnt >= limit) begin cnt_nxt = '0; wrap = 1'b1; end
                    else cnt_nxt = cnt + W'(1);
                end else begin
                    if (cnt == '0) begin cnt_nxt = limit; wrap = 1'b1; end
                    else cnt_nxt = cnt - W'(1);
                end
            end else if (limit < W'(2)) begin
                cnt_nxt = '0;
                dir_nxt = 1'b0;
                wrap    = 1'b1;
            end else if (!cdir) begin
                if (cnt >= limit - W'(1)) begin
                    cnt_nxt = cnt - W'(1);
                    dir_nxt = 1'b1;
                    wrap    = 1'b1;
                end else cnt_nxt = cnt + W'(1);
            end else begin
                if (cnt <= W'(1)) begin
                    cnt_nxt = '0;
                    dir_nxt = 1'b0;
                    wrap    = 1'b1;
                end else cnt_nxt = cnt - W'(1);
            end
        end
    end

    // Count and direction registers; a software load overrides a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            cdir <= 1'b0;
        end else begin
            cnt  <= ld ? ld_val : cnt_nxt;
            cdir <= center ? dir_nxt : 1'b0;
        end
    end
endmodule

// File: rtl/tmr_compare.sv
// Compare channel. Detects count == compare while running, qualifies the
// hit by sweep direction according to the align mode, and holds a sticky
// flag that software clears by writing zero.
module tmr_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   aln,
    input  logic         cdir,
    input  logic         clr,
    output logic         flag
);
    import tmr_pkg::*;

    logic hit;
    logic set;

    // Direction qualification of a raw match.
    always_comb begin
        hit = run && (cnt == cmp);
        case (aln)
            ALN_DN:  set = hit && cdir;
            ALN_UP:  set = hit && !cdir;
            default: set = hit;
        endcase
    end

    // Sticky flag; a new hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_core.sv
// Timer counter top. Holds the control, reload (active and shadow) and
// compare registers, decodes the register port and joins the count
// engine, compare channel and sampling-tick generator.
// Assumes: one register access per clock; reads are combinational.
module tmr_core #(
    parameter int W = tmr_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         upd_o,
    output logic         tick_o
);
    import tmr_pkg::*;

    localparam int CTRL_USED = 8;

    logic         run_q, ops_q, dir_q, pre_q;
    logic [1:0]   aln_q, div_q;
    logic [W-1:0] arr_act, arr_sh, cmp_q;
    logic [W-1:0] cnt;
    logic         cdir, wrap, flag;
    logic         center;
    logic         wr_ctrl, wr_rel, wr_cmp, wr_cnt, clr_flag;
    logic [1:0]   aln_new;
    logic         aln_lock;

    assign center   = (aln_q != ALN_EDGE);
    assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
    assign wr_rel   = wr_en && (addr == ADR_RELOAD);
    assign wr_cmp   = wr_en && (addr == ADR_CMP);
    assign wr_cnt   = wr_en && (addr == ADR_COUNT);
    assign clr_flag = wr_en && (addr == ADR_STAT) && !wdata[0];
    assign aln_new  = wdata[CB_ALN +: 2];
    assign aln_lock = run_q && (aln_q == ALN_EDGE) && (aln_new != ALN_EDGE);

    // Control register with one-shot stop and the mode-change lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; ops_q <= 1'b0; dir_q <= 1'b0;
            pre_q <= 1'b0; aln_q <= ALN_EDGE; div_q <= 2'b00;
        end else if (wr_ctrl) begin
            run_q <= wdata[CB_RUN];
            ops_q <= wdata[CB_OPS];
            dir_q <= wdata[CB_DIR];
            pre_q <= wdata[CB_PRE];
            div_q <= wdata[CB_DIV +: 2];
            if (!aln_lock) aln_q <= aln_new;
        end else if (wrap && ops_q) begin
            run_q <= 1'b0;
        end
    end

    // Reload shadow and active limit, with optional buffering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_sh  <= '1;
            arr_act <= '1;
        end else begin
            if (wr_rel) arr_sh <= wdata;
            if (wr_rel && !pre_q)     arr_act <= wdata;
            else if (wrap && pre_q)   arr_act <= arr_sh;
        end
    end

    // Compare value and registered update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            upd_o <= 1'b0;
        end else begin
            if (wr_cmp) cmp_q <= wdata;
            upd_o <= wrap;
        end
    end

    tmr_counter #(.W(W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_q), .center(center),
        .edge_down(dir_q), .limit(arr_act), .ld(wr_cnt), .ld_val(wdata),
        .cnt(cnt), .cdir(cdir), .wrap(wrap)
    );

    tmr_compare #(.W(W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt), .cmp(cmp_q),
        .aln(aln_q), .cdir(cdir), .clr(clr_flag), .flag(flag)
    );

    tmr_tick_gen #(.PW(2)) i_tick (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick_o)
    );

    // Read multiplexer; the direction bit shows the live sweep in center mode.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata[CTRL_USED-1:0] = {div_q, pre_q, aln_q,
                                              center ? cdir : dir_q, ops_q, run_q};
            ADR_RELOAD: rdata = arr_sh;
            ADR_CMP:    rdata = cmp_q;
            ADR_STAT:   rdata[0] = flag;
            ADR_COUNT:  rdata = cnt;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_core_chk.sv
// Assertion checker for tmr_core, attached by bind below.
module tmr_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         run_q,
    input logic         ops_q,
    input logic         dir_q,
    input logic [1:0]   aln_q,
    input logic [1:0]   div_q,
    input logic [W-1:0] cnt,
    input logic [W-1:0] arr_act,
    input logic         flag,
    input logic         clr_flag,
    input logic         upd_o,
    input logic         tick_o
);
    a_r2_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == 2'b00) |-> tick_o);

    a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && aln_q == 2'b00 && !dir_q && cnt == arr_act && !wr_en)
        |=> (cnt == '0 && upd_o));

    a_r4_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && aln_q == 2'b00 && dir_q && cnt == '0 && !wr_en)
        |=> (cnt == $past(arr_act) && upd_o));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag);

    a_r10_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && $past(ops_q) && !$past(wr_en)) |-> !run_q);

    a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && aln_q == 2'b00) |=> (aln_q == 2'b00));
endmodule

bind tmr_core tmr_core_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .run_q(run_q), .ops_q(ops_q),
    .dir_q(dir_q), .aln_q(aln_q), .div_q(div_q), .cnt(cnt), .arr_act(arr_act),
    .flag(flag), .clr_flag(clr_flag), .upd_o(upd_o), .tick_o(tick_o)
);

// File: tb/test_tmr_core.sv
// Self-checking bench for tmr_core: directed corners plus seeded random sweeps.
module test_tmr_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        upd_o, tick_o;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    tmr_core i_tmr_core (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata), .upd_o(upd_o), .tick_o(tick_o));

    always #5 clk = ~clk;

    task automatic chk(input string req, input [15:0] act, input [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input [2:0] a, input [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input [2:0] a, output [15:0] v);
        addr = a; #1; v = rdata;
    endtask

    // Expected position for each mode: 0 up, 1 down, 2 center.
    function automatic int exp_cnt(int kind, int a, int m);
        int k;
        if (kind == 0) return m % (a + 1);
        if (kind == 1) return (a + 1 - (m % (a + 1))) % (a + 1);
        k = m % (2 * (a - 1));
        return (k <= a - 1) ? k : 2 * (a - 1) - k;
    endfunction

    function automatic bit exp_dir(int kind, int a, int m);
        if (kind == 1) return 1'b1;
        if (kind == 0) return 1'b0;
        return (m % (2 * (a - 1))) >= a;
    endfunction

    function automatic bit exp_upd(int kind, int a, int m);
        if (m == 0) return 1'b0;
        if (kind == 0) return (m % (a + 1)) == 0;
        if (kind == 1) return (m % (a + 1)) == 1;
        return ((m % (2 * (a - 1))) == a) || ((m % (2 * (a - 1))) == 0);
    endfunction

    function automatic bit exp_flag(int kind, int aln, int a, int c, int m);
        bit f = 0;
        for (int j = 0; j < m; j++) begin
            if (exp_cnt(kind, a, j) == c) begin
                if (aln == 0 || aln == 3) f = 1;
                else if (aln == 1 && exp_dir(kind, a, j)) f = 1;
                else if (aln == 2 && !exp_dir(kind, a, j)) f = 1;
            end
        end
        return f;
    endfunction

    // Watchdog: an expired run counts as a failure and still summarizes.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int ticks;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and reserved bits
        rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(3'd1, v); chk("R1 reload", v, 16'hFFFF);
        rd(3'd2, v); chk("R1 compare", v, 16'h0000);
        rd(3'd3, v); chk("R1 status", v, 16'h0000);
        rd(3'd4, v); chk("R1 count", v, 16'h0000);
        wr(3'd0, 16'hFF00);
        rd(3'd0, v); chk("R1 upper ctrl bits", v, 16'h0000);

        // R2 tick rates per divider code, counter stopped
        for (int d = 0; d < 4; d++) begin
            wr(3'd0, 16'(d << 6));
            ticks = 0;
            for (int i = 0; i < 16; i++) begin @(negedge clk); ticks += int'(tick_o); end
            chk("R2 ticks per 16", 16'(ticks), (d == 1) ? 16'd8 : (d == 2) ? 16'd4 : 16'd16);
        end
        wr(3'd0, 16'h0000);

        // R8 unbuffered reload takes effect at once
        wr(3'd1, 16'd20); wr(3'd1, 16'd4); wr(3'd4, 16'd0);
        wr(3'd0, 16'h0001);
        repeat (10) @(negedge clk);
        rd(3'd4, v); chk("R8 count with immediate reload", v, 16'd0);
        wr(3'd0, 16'h0000);

        // R9 buffered reload waits for an update event
        wr(3'd1, 16'd20); wr(3'd0, 16'h0020); wr(3'd1, 16'd4);
        rd(3'd1, v); chk("R9 reload reads shadow", v, 16'd4);
        wr(3'd4, 16'd0); wr(3'd0, 16'h0021);
        repeat (10) @(negedge clk);
        rd(3'd4, v); chk("R9 old limit still active", v, 16'd10);
        repeat (18) @(negedge clk);
        rd(3'd4, v); chk("R9 new limit after update", v, 16'd2);
        wr(3'd0, 16'h0000);

        // R10 one-shot stops at first update
        wr(3'd1, 16'd5); wr(3'd4, 16'd0); wr(3'd0, 16'h0003);
        repeat (10) @(negedge clk);
        rd(3'd4, v); chk("R10 count held at 0", v, 16'd0);
        rd(3'd0, v); chk("R10 run cleared", v & 16'h0001, 16'h0000);

        // R11 edge-to-center refused while running, accepted when stopped
        wr(3'd1, 16'd100); wr(3'd4, 16'd0); wr(3'd0, 16'h0001);
        wr(3'd0, 16'h0019);
        rd(3'd0, v); chk("R11 mode kept while running", v & 16'h0019, 16'h0001);
        wr(3'd0, 16'h0000); wr(3'd0, 16'h0018);
        rd(3'd0, v); chk("R11 mode accepted when stopped", v & 16'h0018, 16'h0018);

        // R5 direction bit write ignored in center mode
        wr(3'd0, 16'h000C);
        rd(3'd0, v); chk("R5 dir write ignored", v & 16'h0004, 16'h0000);
        wr(3'd0, 16'h0000);

        // R7 sticky flag: write 1 keeps it, write 0 clears it
        wr(3'd1, 16'd10); wr(3'd2, 16'd3); wr(3'd4, 16'd0); wr(3'd3, 16'd0);
        wr(3'd0, 16'h0001);
        repeat (6) @(negedge clk);
        wr(3'd0, 16'h0000);
        rd(3'd3, v); chk("R7 flag set", v, 16'd1);
        wr(3'd3, 16'd1);
        rd(3'd3, v); chk("R7 write 1 keeps flag", v, 16'd1);
        wr(3'd3, 16'd0);
        rd(3'd3, v); chk("R7 write 0 clears flag", v, 16'd0);

        // R3 R4 R5 R6 random sweeps against closed-form positions
        for (int it = 0; it < 40; it++) begin
            int kind, aln, a, c, m;
            kind = int'($urandom_range(0, 2));
            aln  = (kind == 2) ? int'($urandom_range(1, 3)) : 0;
            a    = (kind == 2) ? int'($urandom_range(3, 40)) : int'($urandom_range(1, 40));
            c    = int'($urandom_range(0, a));
            m    = int'($urandom_range(0, 120));
            wr(3'd0, 16'h0000); wr(3'd1, 16'(a)); wr(3'd2, 16'(c));
            wr(3'd4, 16'd0); wr(3'd3, 16'd0);
            wr(3'd0, 16'((aln << 3) | ((kind == 1) ? 4 : 0) | 1));
            repeat (m) @(negedge clk);
            rd(3'd4, v);
            chk(kind == 0 ? "R3 count" : kind == 1 ? "R4 count" : "R5 count",
                v, 16'(exp_cnt(kind, a, m)));
            chk(kind == 0 ? "R3 update" : kind == 1 ? "R4 update" : "R5 update",
                16'(upd_o), 16'(exp_upd(kind, a, m)));
            rd(3'd0, v); chk("R5 direction bit", (v >> 2) & 16'h1, 16'(exp_dir(kind, a, m)));
            rd(3'd3, v); chk("R6 compare flag", v, 16'(exp_flag(kind, aln, a, c, m)));
        end
        wr(3'd0, 16'h0000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule